// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the running time of a precision time protocol clock as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock cycle the nanoseconds advance by a programmable step. The step is a whole number of nanoseconds plus a 16-bit binary fraction. A fraction accumulator turns the fractional part into an occasional extra nanosecond. When the nanoseconds reach one billion, they wrap and carry into the seconds.

Software controls the counter through a single-cycle write strobe with a register select. It can load the time, program the step, and apply a one-shot signed nanosecond correction. A combinational read port returns the nanoseconds word and either seconds word. A snapshot strobe freezes a copy of the time for event timestamping.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the nanoseconds, the seconds, the active whole step, the active fraction and the accumulator are all zero, so the time does not move until a step is programmed.
- R2: Each cycle the nanoseconds grow by the active whole step (write select 4, data bits 7:0), plus one when the 16-bit fraction accumulator overflows while adding the active fraction. With a fraction of 0x8000, 10 cycles add 10×whole+5.
- R3: When nanoseconds plus step reach 1,000,000,000, the nanoseconds drop by 1,000,000,000 and the seconds increase by one. The seconds wrap from 2^48−1 to 0.
- R4: A fraction write (write select 3, data bits 15:0) is only held pending. It becomes active together with the next whole-step write, and it does not change the rate before then.
- R5: A seconds-high write (write select 2, data bits 15:0) changes no visible time. A seconds-low write (write select 1) loads seconds = {pending high, data}, and that loaded value wins over any carry in the same cycle.
- R6: A nanoseconds write (write select 0, data bits 29:0) loads the value exactly in that cycle. No step is added and no carry is made in that cycle.
- R7: An adjust write (write select 5) with bit 31 = 0 adds the magnitude in bits 29:0 to the nanoseconds. If the result reaches 1,000,000,000 it wraps and carries one second. No step is added in that cycle.
- R8: An adjust write with bit 31 = 1 subtracts the magnitude. If the magnitude exceeds the nanoseconds, one second is borrowed and 1,000,000,000 is added.
- R9: Read select 0 returns {2'b0, nanoseconds}, select 1 returns seconds bits 31:0, select 2 returns {16'b0, seconds bits 47:32}, and select 3 returns 0.
- R10: A snapshot request captures the time present at that clock edge. On the next cycle the snapshot outputs hold that time and the valid output is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read word select |
| rd_data | output | 32 | Read data |
| snap_req | input | 1 | Snapshot request |
| snap_valid | output | 1 | Snapshot captured last edge |
| snap_sec | output | 48 | Captured seconds |
| snap_ns | output | 30 | Captured nanoseconds |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The embedded assertions check these properties on every cycle:
- the nanoseconds stay below one billion;
- with no write, the seconds change by at most one;
- a zero step with no write freezes the time;
- a nanoseconds load and a snapshot both return exactly the values seen at the edge;
- the active fraction holds between whole-step writes.

Only the directed scenarios can show the following:
- the exact rate with fractional carries;
- the staging order of the step registers;
- the rollover and the 2^48 seconds wrap;
- the split seconds load;
- the signed adjust with carry and borrow.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int SEC_W      = 48;
    localparam int NS_W       = 30;
    localparam int DATA_W     = 32;
    localparam int INC_NS_W   = 8;
    localparam int INC_FRAC_W = 16;
    localparam int SEC_LO_W   = 32;
    localparam int SEC_HI_W   = SEC_W - SEC_LO_W;
    localparam int ADJ_SIGN_BIT = 31;

    localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

    typedef enum logic [2:0] {
        WR_NS       = 3'd0,
        WR_SEC_LO   = 3'd1,
        WR_SEC_HI   = 3'd2,
        WR_INC_FRAC = 3'd3,
        WR_INC_NS   = 3'd4,
        WR_ADJ      = 3'd5
    } wr_sel_e;

    typedef enum logic [1:0] {
        RD_NS     = 2'd0,
        RD_SEC_LO = 2'd1,
        RD_SEC_HI = 2'd2,
        RD_NONE   = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/ptp_tod_step.sv
module ptp_tod_step
    import ptp_tod_pkg::*;
#(
    parameter int NS_STEP_W = INC_NS_W,
    parameter int FRAC_W    = INC_FRAC_W,
    parameter int DW        = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frac_wr,
    input  logic                 whole_wr,
    input  logic [DW-1:0]        wr_data,
    output logic [NS_STEP_W:0]   step
);
    typedef struct packed {
        logic [FRAC_W-1:0]    frac_pend;
        logic [FRAC_W-1:0]    frac_act;
        logic [NS_STEP_W-1:0] whole_act;
        logic [FRAC_W-1:0]    acc;
    } step_st_t;

    step_st_t st_d, st_q;
    logic [FRAC_W:0] acc_sum;

    always_comb begin
        st_d    = st_q;
        acc_sum = {1'b0, st_q.acc} + {1'b0, st_q.frac_act};
        st_d.acc = acc_sum[FRAC_W-1:0];
        step    = {1'b0, st_q.whole_act} + {{NS_STEP_W{1'b0}}, acc_sum[FRAC_W]};
        if (frac_wr) begin
            st_d.frac_pend = wr_data[FRAC_W-1:0];
        end
        if (whole_wr) begin
            st_d.whole_act = wr_data[NS_STEP_W-1:0];
            st_d.frac_act  = st_q.frac_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    frac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !whole_wr |=> $stable(st_q.frac_act));

    // R4
    whole_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !whole_wr |=> $stable(st_q.whole_act));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int SW        = SEC_W,
    parameter int NW        = NS_W,
    parameter int DW        = DATA_W,
    parameter int NS_STEP_W = INC_NS_W,
    parameter int HI_W      = SEC_HI_W,
    parameter int LO_W      = SEC_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic [NS_STEP_W:0]  step,
    output logic [SW-1:0]       sec,
    output logic [NW-1:0]       ns
);
    localparam logic [NW:0] NS_WIDE = {1'b0, NS_PER_SEC};

    typedef struct packed {
        logic [SW-1:0]   sec;
        logic [NW-1:0]   ns;
        logic [HI_W-1:0] hi_pend;
    } tod_st_t;

    tod_st_t st_d, st_q;
    logic [NW:0]   ns_sum;
    logic [NW-1:0] ns_tick;
    logic          tick_carry;
    logic [NW-1:0] mag;
    logic [NW:0]   adj_sum;
    logic [NW-1:0] adj_ns;
    logic [SW-1:0] adj_sec;

    always_comb begin
        ns_sum = {1'b0, st_q.ns} + {{(NW - NS_STEP_W){1'b0}}, step};
        if (ns_sum >= NS_WIDE) begin
            ns_tick    = NW'(ns_sum - NS_WIDE);
            tick_carry = 1'b1;
        end else begin
            ns_tick    = ns_sum[NW-1:0];
            tick_carry = 1'b0;
        end
    end

    always_comb begin
        mag     = wr_data[NW-1:0];
        adj_sum = '0;
        if (wr_data[ADJ_SIGN_BIT]) begin
            if (mag > st_q.ns) begin
                adj_sum = {1'b0, st_q.ns} + NS_WIDE - {1'b0, mag};
                adj_sec = st_q.sec - SW'(1);
            end else begin
                adj_sum = {1'b0, st_q.ns} - {1'b0, mag};
                adj_sec = st_q.sec;
            end
            adj_ns = adj_sum[NW-1:0];
        end else begin
            adj_sum = {1'b0, st_q.ns} + {1'b0, mag};
            if (adj_sum >= NS_WIDE) begin
                adj_ns  = NW'(adj_sum - NS_WIDE);
                adj_sec = st_q.sec + SW'(1);
            end else begin
                adj_ns  = adj_sum[NW-1:0];
                adj_sec = st_q.sec;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.ns  = ns_tick;
        st_d.sec = st_q.sec + SW'(tick_carry);
        if (wr_en) begin
            case (wr_sel)
                WR_NS: begin
                    st_d.ns  = wr_data[NW-1:0];
                    st_d.sec = st_q.sec;
                end
                WR_SEC_LO: begin
                    st_d.sec = {st_q.hi_pend, wr_data[LO_W-1:0]};
                end
                WR_SEC_HI: begin
                    st_d.hi_pend = wr_data[HI_W-1:0];
                end
                WR_ADJ: begin
                    st_d.ns  = adj_ns;
                    st_d.sec = adj_sec;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec = st_q.sec;
    assign ns  = st_q.ns;

    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ns < NS_PER_SEC);

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (st_q.sec == $past(st_q.sec)) || (st_q.sec == $past(st_q.sec) + SW'(1)));

    // R1
    stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0 && !wr_en) |=> ($stable(st_q.ns) && $stable(st_q.sec)));

    // R6
    ns_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_NS) |=> (st_q.ns == $past(wr_data[NW-1:0]) && $stable(st_q.sec)));

    // R5
    hi_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WR_SEC_HI) |=>
            ((st_q.sec == $past(st_q.sec)) || (st_q.sec == $past(st_q.sec) + SW'(1))));
endmodule

// File: rtl/ptp_tod_snap.sv
module ptp_tod_snap
    import ptp_tod_pkg::*;
#(
    parameter int SW = SEC_W,
    parameter int NW = NS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [SW-1:0] tod_sec,
    input  logic [NW-1:0] tod_ns,
    output logic          valid,
    output logic [SW-1:0] cap_sec,
    output logic [NW-1:0] cap_ns
);
    typedef struct packed {
        logic          valid;
        logic [SW-1:0] sec;
        logic [NW-1:0] ns;
    } snap_st_t;

    snap_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        if (req) begin
            st_d.sec = tod_sec;
            st_d.ns  = tod_ns;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid   = st_q.valid;
    assign cap_sec = st_q.sec;
    assign cap_ns  = st_q.ns;

    // R10
    snap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (valid && cap_ns == $past(tod_ns) && cap_sec == $past(tod_sec)));

    // R10
    snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              snap_req,
    output logic              snap_valid,
    output logic [SEC_W-1:0]  snap_sec,
    output logic [NS_W-1:0]   snap_ns,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);
    logic              frac_wr;
    logic              whole_wr;
    logic [INC_NS_W:0] step;

    assign frac_wr  = wr_en && (wr_sel == WR_INC_FRAC);
    assign whole_wr = wr_en && (wr_sel == WR_INC_NS);

    ptp_tod_step #(
        .NS_STEP_W (INC_NS_W),
        .FRAC_W    (INC_FRAC_W),
        .DW        (DATA_W)
    ) i_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .frac_wr  (frac_wr),
        .whole_wr (whole_wr),
        .wr_data  (wr_data),
        .step     (step)
    );

    ptp_tod_clock #(
        .SW        (SEC_W),
        .NW        (NS_W),
        .DW        (DATA_W),
        .NS_STEP_W (INC_NS_W),
        .HI_W      (SEC_HI_W),
        .LO_W      (SEC_LO_W)
    ) i_clock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .step    (step),
        .sec     (tod_sec),
        .ns      (tod_ns)
    );

    ptp_tod_snap #(
        .SW (SEC_W),
        .NW (NS_W)
    ) i_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (snap_req),
        .tod_sec (tod_sec),
        .tod_ns  (tod_ns),
        .valid   (snap_valid),
        .cap_sec (snap_sec),
        .cap_ns  (snap_ns)
    );

    always_comb begin
        case (rd_sel)
            RD_NS:     rd_data = {{(DATA_W - NS_W){1'b0}}, tod_ns};
            RD_SEC_LO: rd_data = tod_sec[SEC_LO_W-1:0];
            RD_SEC_HI: rd_data = {{(DATA_W - SEC_HI_W){1'b0}}, tod_sec[SEC_W-1:SEC_LO_W]};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: tb/test_ptp_tod_counter.sv
module test_ptp_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        snap_req = 1'b0;
    logic        snap_valid;
    logic [47:0] snap_sec;
    logic [29:0] snap_ns;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    localparam longint BILLION = 64'd1_000_000_000;

    ptp_tod_counter i_ptp_tod_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .snap_req(snap_req), .snap_valid(snap_valid),
        .snap_sec(snap_sec), .snap_ns(snap_ns), .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output longint val);
        rd_sel = sel;
        #1;
        val = longint'(rd_data);
    endtask

    task automatic freeze();
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
    endtask

    task automatic set_time(input longint s, input longint n);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'(s >> 32));
        wr(3'd1, 32'(s));
        wr(3'd0, 32'(n));
    endtask

    task automatic t_reset();
        longint v;
        check("R1 ns", tod_ns, 0);
        check("R1 sec", tod_sec, 0);
        repeat (10) @(negedge clk);
        check("R1 stopped ns", tod_ns, 0);
        rd(2'd0, v); check("R9 rd ns reset", v, 0);
        check("R10 snap_valid reset", snap_valid, 0);
    endtask

    task automatic t_whole_rate();
        longint a;
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd8);
        a = tod_ns;
        repeat (10) @(negedge clk);
        check("R2 whole rate", tod_ns - a, 80);
        freeze();
    endtask

    task automatic t_frac_staging();
        longint a;
        wr(3'd3, 32'h8000);
        a = tod_ns;
        repeat (5) @(negedge clk);
        check("R4 pending frac no effect", tod_ns - a, 0);
        wr(3'd4, 32'd8);
        a = tod_ns;
        repeat (10) @(negedge clk);
        check("R2 frac rate", tod_ns - a, 85);
        wr(3'd3, 32'd0);
        a = tod_ns;
        repeat (10) @(negedge clk);
        check("R4 frac still active before whole write", tod_ns - a, 85);
        freeze();
    endtask

    task automatic t_split_seconds();
        longint v;
        freeze();
        set_time(64'h0000_1111_2222_3333, 64'd7);
        wr(3'd2, 32'h0000_ABCD);
        check("R5 hi write no latch", tod_sec, 64'h0000_1111_2222_3333);
        wr(3'd1, 32'h1357_9BDF);
        check("R5 lo write loads", tod_sec, 64'h0000_ABCD_1357_9BDF);
        rd(2'd1, v); check("R9 rd sec lo", v, 64'h1357_9BDF);
        rd(2'd2, v); check("R9 rd sec hi", v, 64'hABCD);
        rd(2'd0, v); check("R9 rd ns", v, 7);
        rd(2'd3, v); check("R9 rd unused", v, 0);
    endtask

    task automatic t_rollover();
        freeze();
        set_time(64'd100, BILLION - 10);
        wr(3'd4, 32'd8);
        repeat (2) @(negedge clk);
        check("R3 rollover ns", tod_ns, 6);
        check("R3 rollover sec", tod_sec, 101);
        freeze();
        set_time(64'hFFFF_FFFF_FFFF, BILLION - 10);
        wr(3'd4, 32'd8);
        repeat (2) @(negedge clk);
        check("R3 wrap sec", tod_sec, 0);
        check("R3 wrap ns", tod_ns, 6);
        freeze();
    endtask

    task automatic t_load_running();
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd8);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'h0000_0002);
        wr(3'd1, 32'h0000_0005);
        check("R5 load while running no carry", tod_sec, 64'h0002_0000_0005);
        wr(3'd0, 32'(BILLION - 1));
        check("R6 ns load exact", tod_ns, BILLION - 1);
        check("R6 sec unchanged on ns load", tod_sec, 64'h0002_0000_0005);
        freeze();
    endtask

    task automatic t_adjust();
        freeze();
        set_time(64'd10, 64'd500);
        wr(3'd5, 32'd100);
        check("R7 add", tod_ns, 600);
        wr(3'd5, 32'h8000_0000 | 32'd100);
        check("R8 sub", tod_ns, 500);
        wr(3'd0, 32'd50);
        wr(3'd5, 32'h8000_0000 | 32'd100);
        check("R8 borrow ns", tod_ns, BILLION - 50);
        check("R8 borrow sec", tod_sec, 9);
        wr(3'd5, 32'd100);
        check("R7 carry ns", tod_ns, 50);
        check("R7 carry sec", tod_sec, 10);
    endtask

    task automatic t_snapshot();
        longint n0, s0;
        wr(3'd4, 32'd3);
        @(negedge clk);
        snap_req = 1'b1;
        n0 = tod_ns; s0 = tod_sec;
        @(negedge clk);
        snap_req = 1'b0;
        check("R10 valid", snap_valid, 1);
        check("R10 ns", snap_ns, n0);
        check("R10 sec", snap_sec, s0);
        @(negedge clk);
        check("R10 one pulse", snap_valid, 0);
        freeze();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_whole_rate();
        t_frac_staging();
        t_split_seconds();
        t_rollover();
        t_load_running();
        t_adjust();
        t_snapshot();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule